// File: doc/BRIEF.md
# Downstream Port Power Supervisor

This block drives the power switches of up to seven downstream ports and watches the over-current flag that each switch reports. Software raises one-cycle strobes to switch a port's power on or off. The block drives one active-low enable per port and reads one active-low fault flag per port. A fault flag that stays low long enough while its port is powered counts as a real over-current. The block then cuts power and records the event in a sticky per-port bit. Software clears that bit with a write-one-to-clear strobe.

A fault flag that goes low for a short time, such as the inrush when a device is plugged in, is filtered out. A fault flag is also ignored while its port is unpowered. A strap input selects the control mode. In individual mode every port is switched and protected on its own. In ganged mode all ports share one power state. A request on any port bit acts on every port, and a fault on any port shuts down and flags every port. Delays are counted in cycles of the reference clock, which is 30 MHz by default.

Top module: `port_power_supervisor`

## Requirements
- R1: After reset every `pwr_en_n` bit is 1 (power off) and every `oc_change` bit is 0.
- R2: In individual mode, a 1 on `pwr_on_req[i]` drives `pwr_en_n[i]` to 0 on the following clock edge, and a 1 on `pwr_off_req[i]` drives it to 1. When both are set for the same port in the same cycle, the off request wins.
- R3: `oc_n[i]` goes low and stays low while port i is powered. Power is then removed exactly Q+2 clock edges after the first edge that samples it low, where Q is the number of clock cycles in 500 µs (15000 at 30 MHz). That is 500.07 µs, which is inside the 500 to 625 µs window. Before that edge, power stays on.
- R4: A low on `oc_n[i]` that lasts Q-1 edges or fewer has no effect. The filter restarts from zero each time the flag returns high.
- R5: While port i is unpowered, `oc_n[i]` is ignored. It neither sets `oc_change[i]` nor affects later behaviour.
- R6: A qualified over-current sets `oc_change[i]` in the same edge that removes power. The bit then stays 1 until a 1 on `oc_clear[i]`. If a trip and a clear strobe land on the same edge, the trip wins.
- R7: After an over-current trip the port stays unpowered even when `oc_n` returns high. Only a new `pwr_on_req` powers it again.
- R8: In ganged mode (`gang_mode`=1), a 1 on any bit of `pwr_on_req` powers all ports, and a 1 on any bit of `pwr_off_req` unpowers all ports. A qualified over-current on any port unpowers all ports and sets every `oc_change` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gang_mode | input | 1 | Strap: 1 = ganged, 0 = individual |
| pwr_on_req | input | NUM_PORTS | One-cycle power-on strobes, one per port |
| pwr_off_req | input | NUM_PORTS | One-cycle power-off strobes, one per port |
| oc_clear | input | NUM_PORTS | Write-one-to-clear strobes for the sticky bits |
| oc_n | input | NUM_PORTS | Active-low over-current flags from the switches |
| pwr_en_n | output | NUM_PORTS | Active-low power-enable outputs |
| oc_change | output | NUM_PORTS | Sticky over-current event bits |

## Verification
The hardest cases to reach are the edges of the qualification window. A fault that lasts one cycle less than the threshold must not trip the port, and a fault that lasts exactly the threshold must trip it on one exact edge. The bench builds the design with a slow clock parameter, so the threshold is 50 cycles. It drives the fault flag away from the clock edge and counts edges from the first sampling edge. It then checks the enable just before and exactly at the expected edge. To test that a trip beats a clear strobe, the clear strobe is placed on the same edge as the trip.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // Number of reference clock cycles in a span given in microseconds.
  function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned us);
    return int'((clk_hz / 64'd1000) * us / 64'd1000);
  endfunction
endpackage

// File: rtl/pps_oc_sync.sv
module pps_oc_sync #(
  parameter int NUM_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] oc_n,
  output logic [NUM_PORTS-1:0] oc_hit
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_sync
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= ~oc_n[g];
        stage2 <= stage1;
      end
    end
    assign oc_hit[g] = stage2;
  end
endmodule

// File: rtl/pps_qual_filter.sv
module pps_qual_filter #(
  parameter int NUM_PORTS   = 7,
  parameter int QUAL_CYCLES = 15000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] oc_hit,
  input  logic [NUM_PORTS-1:0] armed,
  output logic [NUM_PORTS-1:0] trip
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_filt
    logic [CW-1:0] run;
    logic          live;
    assign live    = oc_hit[g] & armed[g];
    assign trip[g] = live & (run == LAST);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run <= '0;
      else if (!live || trip[g]) run <= '0;
      else                     run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/pps_power_ctrl.sv
module pps_power_ctrl #(
  parameter int NUM_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gang_mode,
  input  logic [NUM_PORTS-1:0] on_req,
  input  logic [NUM_PORTS-1:0] off_req,
  input  logic [NUM_PORTS-1:0] clr_req,
  input  logic [NUM_PORTS-1:0] trip,
  output logic [NUM_PORTS-1:0] powered,
  output logic [NUM_PORTS-1:0] sticky
);
  logic [NUM_PORTS-1:0] on_eff, off_eff, trip_eff;

  always_comb begin
    if (gang_mode) begin
      on_eff   = {NUM_PORTS{|on_req}};
      off_eff  = {NUM_PORTS{|off_req}};
      trip_eff = {NUM_PORTS{|trip}};
    end else begin
      on_eff   = on_req;
      off_eff  = off_req;
      trip_eff = trip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      powered <= '0;
      sticky  <= '0;
    end else begin
      powered <= (powered | on_eff) & ~off_eff & ~trip_eff;
      sticky  <= (sticky & ~clr_req) | trip_eff;
    end
  end
endmodule

// File: rtl/port_power_supervisor.sv
module port_power_supervisor #(
  parameter int          NUM_PORTS = 7,
  parameter longint      CLK_HZ    = 30_000_000,
  parameter longint      QUAL_US   = 500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gang_mode,
  input  logic [NUM_PORTS-1:0] pwr_on_req,
  input  logic [NUM_PORTS-1:0] pwr_off_req,
  input  logic [NUM_PORTS-1:0] oc_clear,
  input  logic [NUM_PORTS-1:0] oc_n,
  output logic [NUM_PORTS-1:0] pwr_en_n,
  output logic [NUM_PORTS-1:0] oc_change
);
  localparam int QUAL_CYCLES = pps_pkg::us_to_cycles(CLK_HZ, QUAL_US);

  logic [NUM_PORTS-1:0] oc_hit, trip, powered;

  pps_oc_sync #(.NUM_PORTS(NUM_PORTS)) u_sync (
    .clk(clk), .rst_n(rst_n), .oc_n(oc_n), .oc_hit(oc_hit)
  );

  pps_qual_filter #(.NUM_PORTS(NUM_PORTS), .QUAL_CYCLES(QUAL_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .oc_hit(oc_hit), .armed(powered), .trip(trip)
  );

  pps_power_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .gang_mode(gang_mode),
    .on_req(pwr_on_req), .off_req(pwr_off_req), .clr_req(oc_clear),
    .trip(trip), .powered(powered), .sticky(oc_change)
  );

  assign pwr_en_n = ~powered;
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int NUM_PORTS   = 7,
  parameter int QUAL_CYCLES = 15000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gang_mode,
  input logic [NUM_PORTS-1:0] pwr_off_req,
  input logic [NUM_PORTS-1:0] oc_clear,
  input logic [NUM_PORTS-1:0] oc_n,
  input logic [NUM_PORTS-1:0] pwr_en_n,
  input logic [NUM_PORTS-1:0] oc_change
);
  localparam int CW = $clog2(QUAL_CYCLES + 4);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
    logic [CW-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_run <= '0;
      else if (!oc_n[g] && !pwr_en_n[g]) low_run <= (low_run == SAT) ? low_run : low_run + 1'b1;
      else                              low_run <= '0;
    end

    // R2: an off strobe in individual mode always unpowers the port
    a_r2_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_off_req[g]) && !$past(gang_mode)) |-> pwr_en_n[g]);

    // R3: no individual trip before the fault has been seen for the full window
    a_r3_min_delay: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(oc_change[g]) && !$past(gang_mode)) |-> (low_run >= CW'(QUAL_CYCLES)));

    // R3: power is never held beyond the window while the fault persists
    a_r3_max_delay: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en_n[g] |-> (low_run <= CW'(QUAL_CYCLES + 1)));

    // R5: an unpowered port cannot raise its own event
    a_r5_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_en_n[g]) && !$past(gang_mode)) |-> !$rose(oc_change[g]));

    // R6: the sticky bit only falls after a clear strobe
    a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(oc_change[g]) && !$past(oc_clear[g])) |-> oc_change[g]);

    // R6: a trip removes power on the same edge as the event bit rises
    a_r6_trip_unpowers: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oc_change[g]) |-> pwr_en_n[g]);
  end

  // R8: ganged ports that agree keep agreeing
  a_r8_gang_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gang_mode) && ($past(pwr_en_n) == '0 || $past(pwr_en_n) == {NUM_PORTS{1'b1}}))
      |-> (pwr_en_n == '0 || pwr_en_n == {NUM_PORTS{1'b1}}));
endmodule

bind port_power_supervisor pps_checker #(
  .NUM_PORTS(NUM_PORTS), .QUAL_CYCLES(QUAL_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gang_mode(gang_mode), .pwr_off_req(pwr_off_req),
  .oc_clear(oc_clear), .oc_n(oc_n), .pwr_en_n(pwr_en_n), .oc_change(oc_change)
);

// File: tb/sim_port_power_supervisor.sv
`timescale 1ns/1ps
module sim_port_power_supervisor;
  localparam int N = 7;
  localparam int Q = 50;            // 500 us at a 100 kHz reference
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gang_mode = 1'b0;
  logic [N-1:0] pwr_on_req = '0, pwr_off_req = '0, oc_clear = '0, oc_n = ALL;
  logic [N-1:0] pwr_en_n, oc_change;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  port_power_supervisor #(.NUM_PORTS(N), .CLK_HZ(100_000), .QUAL_US(500)) u0 (
    .clk(clk), .rst_n(rst_n), .gang_mode(gang_mode), .pwr_on_req(pwr_on_req),
    .pwr_off_req(pwr_off_req), .oc_clear(oc_clear), .oc_n(oc_n),
    .pwr_en_n(pwr_en_n), .oc_change(oc_change)
  );

  // {gang, on, off, expected pwr_en_n}
  localparam logic [21:0] TBL [9] = '{
    {1'b0, 7'b0000101, 7'b0000000, 7'b1111010},
    {1'b0, 7'b0000010, 7'b0000000, 7'b1111000},
    {1'b0, 7'b0000000, 7'b0000001, 7'b1111001},
    {1'b0, 7'b1000000, 7'b1000000, 7'b1111001},
    {1'b0, 7'b0000000, 7'b0000110, 7'b1111111},
    {1'b1, 7'b0000100, 7'b0000000, 7'b0000000},
    {1'b1, 7'b0000000, 7'b0100000, 7'b1111111},
    {1'b1, 7'b0000001, 7'b0000000, 7'b0000000},
    {1'b0, 7'b0000000, 7'b1111111, 7'b1111111}
  };

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_on(input logic [N-1:0] m);
    pwr_on_req = m; edges(1); pwr_on_req = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%b expected=%b", 1'b0, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    edges(3);
    chk(pwr_en_n == ALL, "R1 enables off in reset", pwr_en_n, ALL);
    chk(oc_change == '0, "R1 status clear in reset", oc_change, '0);
    rst_n = 1'b1;
    edges(2);
    chk(pwr_en_n == ALL && oc_change == '0, "R1 state after reset", pwr_en_n, ALL);

    // R2 / R8 command table
    foreach (TBL[i]) begin
      gang_mode   = TBL[i][21];
      pwr_on_req  = TBL[i][20:14];
      pwr_off_req = TBL[i][13:7];
      edges(1);
      pwr_on_req = '0; pwr_off_req = '0;
      chk(pwr_en_n == TBL[i][6:0], TBL[i][21] ? "R8 gang command" : "R2 port command",
          pwr_en_n, TBL[i][6:0]);
    end
    gang_mode = 1'b0;

    // R3: exact trip edge on port 2
    pulse_on(7'b0000100);
    oc_n[2] = 1'b0;
    edges(Q + 1);
    chk(pwr_en_n[2] == 1'b0, "R3 still powered one edge early", pwr_en_n, 7'b1111011);
    edges(1);
    chk(pwr_en_n[2] == 1'b1, "R3 power removed at Q+2", pwr_en_n, ALL);
    chk(oc_change == 7'b0000100, "R6 event bit set", oc_change, 7'b0000100);

    // R7: stays off after fault clears
    oc_n[2] = 1'b1;
    edges(10);
    chk(pwr_en_n == ALL, "R7 no auto re-power", pwr_en_n, ALL);
    pulse_on(7'b0000100);
    chk(pwr_en_n == 7'b1111011, "R7 re-power on request", pwr_en_n, 7'b1111011);

    // R6: clear of another bit has no effect, then clear own bit
    oc_clear = 7'b0000001; edges(1); oc_clear = '0;
    chk(oc_change == 7'b0000100, "R6 clear other bit", oc_change, 7'b0000100);
    oc_clear = 7'b0000100; edges(1); oc_clear = '0;
    chk(oc_change == '0, "R6 clear own bit", oc_change, '0);

    // R4: two short faults of Q-1 edges
    for (int r = 0; r < 2; r++) begin
      oc_n[2] = 1'b0; edges(Q - 1); oc_n[2] = 1'b1; edges(4);
    end
    chk(pwr_en_n == 7'b1111011 && oc_change == '0, "R4 short faults filtered", pwr_en_n, 7'b1111011);

    // R5: fault on unpowered port 3
    oc_n[3] = 1'b0; edges(3 * Q);
    chk(oc_change == '0, "R5 unpowered fault ignored", oc_change, '0);
    oc_n[3] = 1'b1; edges(4);
    pulse_on(7'b0001000);
    edges(5);
    chk(pwr_en_n == 7'b1110011, "R5 port powers normally afterwards", pwr_en_n, 7'b1110011);

    // R8 + R6: ganged trip from port 5, with a clear on the trip edge
    gang_mode = 1'b1;
    pulse_on(7'b0000001);
    chk(pwr_en_n == '0, "R8 gang on", pwr_en_n, '0);
    oc_n[5] = 1'b0;
    edges(Q + 1);
    chk(pwr_en_n == '0, "R8 gang still powered", pwr_en_n, '0);
    oc_clear = ALL; edges(1); oc_clear = '0;
    chk(pwr_en_n == ALL, "R8 gang trip unpowers all", pwr_en_n, ALL);
    chk(oc_change == ALL, "R6 trip beats clear, R8 all flagged", oc_change, ALL);
    oc_n[5] = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule